// File: doc/BRIEF.md
# Two-Bank Interleaved Word Memory

This block is a word-addressed memory front end made of two physical banks. Address bit 0 picks the bank: even words live in bank 0 and odd words in bank 1. The remaining upper address bits form the row inside that bank. A requester offers at most one access per cycle. Each access carries an address, a read/write flag, write data and a tag.

Every access holds its bank for two cycles. An access to the bank that was issued in the previous cycle is refused with `stall`, and the requester keeps it on the inputs until it is taken. An access to the other bank issues at once, so the two bank operations overlap. A stream of sequential addresses therefore flows at one word per cycle.

Read data comes back with its tag on one of two destination pads, one pad per bank, so overlapped returns never share a register. Latency is fixed, so returns come out in issue order.

Top module: `ilv_mem`

## Requirements
- R1: The bank is `req_addr[0]` and the row within the bank is `req_addr[AW-1:1]`. A read returns the word most recently written to the same full address.
- R2: A read issued in cycle c (`req_valid`=1, `stall`=0, `req_write`=0) raises the pad valid bit for exactly one cycle, in cycle c+2.
- R3: When an access was issued in cycle c, a request in cycle c+1 to the same bank sees `stall`=1, is not taken, and issues in cycle c+2 if it is held.
- R4: A request to the bank that was not used in the previous cycle sees `stall`=0 and issues in that cycle, so an alternating-bank stream never stalls.
- R5: Bank 0 returns on pad 0 (`pad_valid[0]`, `pad_data[DW-1:0]`, `pad_tag[TW-1:0]`). Bank 1 returns on pad 1 (the upper slices). Each return carries the tag of its request.
- R6: A write holds its bank for the same two cycles as a read and produces no pad return.
- R7: `stall` is 0 whenever `req_valid` is 0.
- R8: While reset is asserted and right after it, both pad valid bits are 0 and `stall` is 0 for an idle requester.
- R9: Returns appear in the same order in which their reads were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access offered this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address; bit 0 selects the bank |
| req_wdata | input | DW | Write data |
| req_tag | input | TW | Tag returned with read data |
| stall | output | 1 | Access refused this cycle; hold it |
| pad_valid | output | 2 | Per-pad return strobe, bit b = bank b |
| pad_data | output | 2*DW | Pad data, pad b at [b*DW +: DW] |
| pad_tag | output | 2*TW | Pad tag, pad b at [b*TW +: TW] |

## Verification
Several things can land in one cycle. A read return can appear on one pad while a new access to the other bank is issued. A write can commit in one bank while the other bank's pad returns data. A stall decision can also come from the previous cycle's write. The bench sweeps every ordered pair of addresses in a small configuration, with the first access of each pair a write on a fixed arithmetic pattern. In each cycle it compares `stall` and both pads against a model that tracks the previous issue and a shadow copy of the memory.

// File: rtl/ilv_mem.sv
module ilv_mem #(
  parameter int DW = 38,
  parameter int AW = 6,
  parameter int TW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [TW-1:0]   req_tag,
  output logic            stall,
  output logic [1:0]      pad_valid,
  output logic [2*DW-1:0] pad_data,
  output logic [2*TW-1:0] pad_tag
);
  localparam int RW = AW - 1;
  localparam int DEPTH = 1 << RW;

  logic [1:0] busy;
  wire bsel = req_addr[0];
  wire fire = req_valid & ~stall;

  assign stall = req_valid & busy[bsel];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic          s_vld, s_wr;
    logic [RW-1:0] s_row;
    logic [DW-1:0] s_dat;
    logic [TW-1:0] s_tag;
    logic          p_vld;
    logic [DW-1:0] p_dat;
    logic [TW-1:0] p_tag;
    wire take = fire & (bsel == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_vld <= 1'b0;
        p_vld <= 1'b0;
      end else begin
        s_vld <= take;
        p_vld <= s_vld & ~s_wr;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        s_wr  <= req_write;
        s_row <= req_addr[AW-1:1];
        s_dat <= req_wdata;
        s_tag <= req_tag;
      end
      if (s_vld && s_wr) mem[s_row] <= s_dat;
      if (s_vld && !s_wr) begin
        p_dat <= mem[s_row];
        p_tag <= s_tag;
      end
    end

    assign busy[b] = s_vld;
    assign pad_valid[b] = p_vld;
    assign pad_data[b*DW +: DW] = p_dat;
    assign pad_tag[b*TW +: TW] = p_tag;
  end
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk #(
  parameter int DW = 38,
  parameter int AW = 6,
  parameter int TW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic [TW-1:0]   req_tag,
  input logic            stall,
  input logic [1:0]      pad_valid,
  input logic [2*DW-1:0] pad_data,
  input logic [2*TW-1:0] pad_tag
);
  wire issued = req_valid && !stall;

  assert_idle_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !stall);

  assert_same_bank_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issued |=> (!(req_valid && req_addr[0] == $past(req_addr[0])) || stall));

  assert_alt_bank_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issued |=> (!(req_valid && req_addr[0] != $past(req_addr[0])) || !stall));

  assert_read_ret_bank0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && !req_write && !req_addr[0]) |-> ##2 pad_valid[0]);

  assert_read_ret_bank1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && !req_write && req_addr[0]) |-> ##2 pad_valid[1]);

  assert_pad0_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_valid[0] |-> $past(issued && !req_write && !req_addr[0], 2));

  assert_pad1_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_valid[1] |-> $past(issued && !req_write && req_addr[0], 2));

  assert_pad0_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_valid[0] |-> pad_tag[TW-1:0] == $past(req_tag, 2));

  assert_pad1_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_valid[1] |-> pad_tag[2*TW-1:TW] == $past(req_tag, 2));

  assert_one_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_valid));
endmodule

bind ilv_mem ilv_mem_chk #(.DW(DW), .AW(AW), .TW(TW)) u_chk (.*);

// File: tb/ilv_mem_tb.sv
module ilv_mem_tb;
  localparam int DW = 38;
  localparam int AW = 4;
  localparam int TW = 4;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW-1:0] req_tag = '0;
  logic stall;
  logic [1:0] pad_valid;
  logic [2*DW-1:0] pad_data;
  logic [2*TW-1:0] pad_tag;

  always #5 clk = ~clk;

  ilv_mem #(.DW(DW), .AW(AW), .TW(TW)) u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] model [NA];
  logic          ev [2][4];
  logic [DW-1:0] ed [2][4];
  logic [TW-1:0] et [2][4];
  logic pf = 1'b0;
  logic pb = 1'b0;
  int stalls = 0;

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a) * 38'h0_1357_9BDF + DW'(k) * 38'd977 + 38'd5;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_pads();
    int s = cyc % 4;
    for (int b = 0; b < 2; b++) begin
      chk(pad_valid[b] == ev[b][s], "R2", 64'(pad_valid[b]), 64'(ev[b][s]));
      if (ev[b][s] && pad_valid[b]) begin
        chk(pad_data[b*DW +: DW] == ed[b][s], "R1", 64'(pad_data[b*DW +: DW]), 64'(ed[b][s]));
        chk(pad_tag[b*TW +: TW] == et[b][s], "R5", 64'(pad_tag[b*TW +: TW]), 64'(et[b][s]));
      end
      ev[b][s] = 1'b0;
    end
  endtask

  task automatic step(input logic v, input logic w, input int a, input logic [DW-1:0] d,
                      input logic [TW-1:0] t, output logic fired);
    logic es;
    int s;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = d; req_tag = t;
    #1;
    es = v && pf && (pb == a[0]);
    if (!v) chk(stall == 1'b0, "R7", 64'(stall), 64'(0));
    else if (es) chk(stall == 1'b1, "R3", 64'(stall), 64'(1));
    else chk(stall == 1'b0, "R4", 64'(stall), 64'(0));
    check_pads();
    fired = v && !es;
    if (es) stalls++;
    pf = fired;
    pb = a[0];
    if (fired && !w) begin
      s = (cyc + 2) % 4;
      ev[a[0]][s] = 1'b1;
      ed[a[0]][s] = model[a];
      et[a[0]][s] = t;
    end
    if (fired && w) model[a] = d;
    cyc++;
  endtask

  task automatic acc(input logic w, input int a, input logic [DW-1:0] d, input logic [TW-1:0] t);
    logic f;
    f = 1'b0;
    while (!f) step(1'b1, w, a, d, t, f);
  endtask

  task automatic idle(input int n);
    logic f;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, '0, '0, f);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int s = 0; s < 4; s++) ev[b][s] = 1'b0;
    for (int a = 0; a < NA; a++) model[a] = '0;
    repeat (2) @(negedge clk);
    // R8: reset state
    chk(pad_valid == 2'b00, "R8", 64'(pad_valid), 64'(0));
    chk(stall == 1'b0, "R8", 64'(stall), 64'(0));
    rst_n = 1'b1;
    idle(2);
    chk(pad_valid == 2'b00, "R8", 64'(pad_valid), 64'(0));

    // R4/R6: sequential write stream, no stall, no returns
    stalls = 0;
    for (int a = 0; a < NA; a++) acc(1'b1, a, pat(a, 0), '0);
    chk(stalls == 0, "R4", 64'(stalls), 64'(0));
    idle(3);

    // R1/R2/R9: sequential read stream returns in order
    stalls = 0;
    for (int a = 0; a < NA; a++) acc(1'b0, a, '0, TW'(a));
    chk(stalls == 0, "R4", 64'(stalls), 64'(0));
    idle(3);

    // R3: same-bank stride stream, one stall per access after the first
    stalls = 0;
    for (int a = 0; a < NA; a += 2) acc(1'b0, a, '0, TW'(a + 3));
    chk(stalls == NA / 2 - 1, "R3", 64'(stalls), 64'(NA / 2 - 1));
    idle(3);

    // R3/R6: write then same-bank read must wait; then read back
    stalls = 0;
    acc(1'b1, 5, pat(5, 9), '0);
    acc(1'b0, 7, '0, 4'h7);
    chk(stalls == 1, "R6", 64'(stalls), 64'(1));
    acc(1'b0, 5, '0, 4'h5);
    idle(3);

    // all ordered pairs, first access a write on a pattern
    for (int a = 0; a < NA; a++) begin
      for (int b = 0; b < NA; b++) begin
        acc(((a + b) % 3) == 0, a, pat(a, b + 1), TW'(a ^ b));
        acc(1'b0, b, '0, TW'(b));
        idle(1);
      end
    end
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule